// File: doc/BRIEF.md
# Partitioned Byte Memory with Address Decode

This block is the memory side of a small processor bus. It has a 16-bit address, an 8-bit data path, a read/write line and an active-low request. The 64K address space is split into five regions: a read-only 8K region at the bottom, three 8K read/write regions above it, and a 2K read/write region at the very top. Everything between 0x8000 and 0xF7FF is an unmapped hole. Each region has its own active-low select, and these selects are brought out as outputs. The block holds the select decode, the storage, and the mux that drives the selected region onto the read data bus.

The read-only region has no storage cells. Its contents are a fixed pattern derived from the address. The read/write regions are real byte storage. Their depth is set by a parameter, so a smaller build mirrors its cells inside each region. The top-level default keeps 512 bytes per region, which holds the elaborated size down. Setting the parameter to 13 gives the full map with no mirroring. Reads are combinational. Writes are taken on the rising clock edge.

Top module: `memsub_map`

## Requirements
- R1: Select index 0 (read-only), 1, 2 and 3 are driven low when the request is active and address bits 15..13 equal 000, 001, 010 and 011 respectively.
- R2: Select index 4 is driven low only when the request is active and address bits 15..11 are all 1 (0xF800–0xFFFF).
- R3: While `mreq_n` is high, all five selects are high. At no time is more than one select low.
- R4: An active access to 0x8000–0xF7FF drives no select low. A read there returns 0xFF. A write there changes no stored byte in any region.
- R5: A read of the read-only region returns address bits 7..0 XOR 0xA5. A write aimed at that region is dropped and leaves the returned value unchanged.
- R6: A write (`rd_wr` = 0) with the request active and a read/write region selected stores `wdata` at the rising edge. A later read of the same address returns that byte.
- R7: When the request is inactive, or `rd_wr` is 0, `rdata` is 0xFF.
- R8: Within each read/write region, only the low `STORE_AW` offset bits pick a cell, where the top-level default `STORE_AW` is 9. Offsets that differ only above those bits reach the same byte.
- R9: Writes are blocked while `rst_n` is low, and at the first two rising edges after it is released. A write during that window leaves the old content in place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes are taken on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 16 | Byte address |
| wdata | input | 8 | Write data |
| rd_wr | input | 1 | 1 = read, 0 = write |
| mreq_n | input | 1 | Active-low memory request |
| rdata | output | 8 | Read data; 0xFF when idle or unmapped |
| sel_n | output | 5 | Active-low region selects: [0] read-only, [1..3] 8K banks, [4] top 2K |

## Verification
The decode is driven with addresses at both edges of every region. It is also driven at the 0xF7FF/0xF800 boundary, and with top bits 111 but bit 12 or bit 11 clear. This separates a correct five-bit match for the top bank from a plain three-bit match. Distinct bytes are written to the same offset in every read/write bank, which exposes any crossed write enable or mux leg. Writes aimed at the hole and at the read-only region are followed by reads of the banks and of the pattern, which shows that such writes leave no trace. A mirrored offset and a reset pulse with writes inside the release window check the cell indexing and the write gating.

// File: rtl/memsub_pkg.sv
package memsub_pkg;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 8;
  localparam int BIG_AW   = 13;
  localparam int SMALL_AW = 11;
  localparam int TOP_BITS = ADDR_W - BIG_AW;
  localparam int NUM_BIG  = 4;
  localparam int NUM_SEL  = NUM_BIG + 1;
  localparam int SEL_ROM   = 0;
  localparam int SEL_SMALL = NUM_BIG;
  localparam int SMALL_EXTRA = BIG_AW - SMALL_AW;

  localparam logic [DATA_W-1:0] ROM_KEY   = 8'hA5;
  localparam logic [DATA_W-1:0] IDLE_BYTE = '1;

  function automatic logic [DATA_W-1:0] rom_pattern(input logic [BIG_AW-1:0] off);
    return off[DATA_W-1:0] ^ ROM_KEY;
  endfunction

endpackage

// File: rtl/memsub_decode.sv
module memsub_decode
  import memsub_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               req,
  output logic [NUM_SEL-1:0] sel_n
);

  logic [NUM_SEL-1:0] hit;
  logic [TOP_BITS-1:0] top_field;

  always_comb top_field = addr[ADDR_W-1 -: TOP_BITS];

  for (genvar g = 0; g < NUM_BIG; g++) begin : g_big
    always_comb hit[g] = (top_field == TOP_BITS'(g));
  end

  always_comb
    hit[SEL_SMALL] = (&top_field) && (&addr[BIG_AW-1 -: SMALL_EXTRA]);

  always_comb sel_n = ~(hit & {NUM_SEL{req}});

endmodule

// File: rtl/memsub_rom.sv
module memsub_rom
  import memsub_pkg::*;
(
  input  logic [BIG_AW-1:0] off,
  output logic [DATA_W-1:0] rd
);

  always_comb rd = rom_pattern(off);

endmodule

// File: rtl/memsub_ram.sv
module memsub_ram #(
  parameter int REGION_AW = 13,
  parameter int STORE_AW  = 9,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [REGION_AW-1:0] off,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd
);

  localparam int CELL_AW = (STORE_AW < REGION_AW) ? STORE_AW : REGION_AW;
  localparam int DEPTH   = 1 << CELL_AW;

  logic [DATA_W-1:0]  mem [DEPTH];
  logic [CELL_AW-1:0] idx;
  logic               unused_off;

  always_comb idx = off[CELL_AW-1:0];
  always_comb unused_off = ^off;

  always_comb rd = mem[idx];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[idx] <= wdata;
    end
  end

endmodule

// File: rtl/memsub_map.sv
module memsub_map
  import memsub_pkg::*;
#(
  parameter int STORE_AW = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [15:0]        addr,
  input  logic [7:0]         wdata,
  input  logic               rd_wr,
  input  logic               mreq_n,
  output logic [7:0]         rdata,
  output logic [4:0]         sel_n
);

  logic [1:0]  rst_sync_q;
  logic [1:0]  rst_sync_d;
  logic        wr_ready;
  logic        req;
  logic        wr_cycle;
  logic        rd_cycle;
  logic [NUM_SEL-1:0] sel_int_n;
  logic [DATA_W-1:0]  bank_rd [NUM_SEL];

  always_comb rst_sync_d = {rst_sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= rst_sync_d;
    end
  end

  always_comb wr_ready = rst_sync_q[1];
  always_comb req      = ~mreq_n;
  always_comb wr_cycle = req & ~rd_wr & wr_ready;
  always_comb rd_cycle = req & rd_wr;

  memsub_decode u_decode (
    .addr  (addr),
    .req   (req),
    .sel_n (sel_int_n)
  );

  memsub_rom u_rom (
    .off (addr[BIG_AW-1:0]),
    .rd  (bank_rd[SEL_ROM])
  );

  for (genvar k = 1; k < NUM_SEL; k++) begin : g_bank
    localparam int RAW = (k == SEL_SMALL) ? SMALL_AW : BIG_AW;
    logic bank_we;
    always_comb bank_we = wr_cycle & ~sel_int_n[k];
    memsub_ram #(
      .REGION_AW (RAW),
      .STORE_AW  (STORE_AW),
      .DATA_W    (DATA_W)
    ) u_ram (
      .clk   (clk),
      .wr_en (bank_we),
      .off   (addr[RAW-1:0]),
      .wdata (wdata),
      .rd    (bank_rd[k])
    );
  end

  always_comb begin
    rdata = IDLE_BYTE;
    if (rd_cycle) begin
      for (int k = 0; k < NUM_SEL; k++) begin
        if (!sel_int_n[k]) rdata = bank_rd[k];
      end
    end
  end

  always_comb sel_n = sel_int_n;

endmodule

// File: rtl/memsub_map_chk.sv
module memsub_map_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic        rd_wr,
  input logic        mreq_n,
  input logic [7:0]  rdata,
  input logic [4:0]  sel_n
);

  // R3
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~sel_n) <= 1);

  // R3
  idle_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mreq_n |-> (sel_n == 5'b11111));

  // R7
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || !rd_wr) |-> (rdata == 8'hFF));

  // R4
  hole_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && addr[15] && (addr[14:11] != 4'hF)) |->
      ((sel_n == 5'b11111) && (!rd_wr || rdata == 8'hFF)));

  // R5
  rom_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && rd_wr && addr[15:13] == 3'd0) |-> (rdata == (addr[7:0] ^ 8'hA5)));

  // R1
  bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && addr[15:13] == 3'd2) |-> (sel_n == 5'b11011));

  // R2
  top_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mreq_n && (&addr[15:11])) |-> (sel_n == 5'b01111));

endmodule

bind memsub_map memsub_map_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .addr   (addr),
  .rd_wr  (rd_wr),
  .mreq_n (mreq_n),
  .rdata  (rdata),
  .sel_n  (sel_n)
);

// File: tb/memsub_map_test.sv
module memsub_map_test;

  localparam int STORE_AW = 9;

  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wdata;
  logic        rd_wr;
  logic        mreq_n;
  logic [7:0]  rdata;
  logic [4:0]  sel_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] exp_rd;
    logic [4:0] exp_sel;
    string      tag;
  } item_t;

  item_t q[$];
  logic [7:0] mdl [int];
  event go;

  memsub_map #(.STORE_AW(STORE_AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_wr(rd_wr), .mreq_n(mreq_n), .rdata(rdata), .sel_n(sel_n)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  // region index per R1/R2; -1 = hole (R4)
  function automatic int region(input logic [15:0] a);
    if (a[15:13] <= 3'd3) return int'(a[15:13]);
    if (&a[15:11]) return 4;
    return -1;
  endfunction

  function automatic logic [4:0] exp_sel(input logic [15:0] a, input logic req);
    int r = region(a);
    if (!req || r < 0) return 5'b11111;
    return ~(5'b00001 << r);
  endfunction

  // R8: cell key uses low STORE_AW offset bits
  function automatic int key(input logic [15:0] a);
    return region(a) * 65536 + int'(a[STORE_AW-1:0]);
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    int r = region(a);
    if (r < 0) return 8'hFF;
    if (r == 0) return a[7:0] ^ 8'hA5;
    if (mdl.exists(key(a))) return mdl[key(a)];
    return 8'hxx;
  endfunction

  task automatic bus_op(input logic [15:0] a, input logic rw, input logic req,
                        input logic [7:0] d, input bit upd, input string tag);
    item_t it;
    @(negedge clk);
    addr = a; rd_wr = rw; mreq_n = ~req; wdata = d;
    it.exp_rd  = (req && rw) ? exp_read(a) : 8'hFF;
    it.exp_sel = exp_sel(a, req);
    it.tag     = tag;
    q.push_back(it);
    -> go;
    if (upd && req && !rw && region(a) > 0) mdl[key(a)] = d;
  endtask

  initial begin
    forever begin
      item_t it;
      @(go);
      #2;
      it = q.pop_front();
      checks++;
      if (rdata !== it.exp_rd) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h", it.tag, rdata, it.exp_rd);
      end
      checks++;
      if (sel_n !== it.exp_sel) begin
        errors++;
        $display("FAIL %s sel_n actual %b expected %b", it.tag, sel_n, it.exp_sel);
      end
    end
  end

  initial begin
    rst_n = 0; addr = 16'h2000; rd_wr = 1; mreq_n = 1; wdata = 0;
    // R3 R7 reset state: idle bus
    bus_op(16'h2000, 1, 0, 8'h00, 1, "R3 reset idle");
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R5 pattern reads
    bus_op(16'h0000, 1, 1, 8'h00, 1, "R5 rom 0000");
    bus_op(16'h1FFF, 1, 1, 8'h00, 1, "R5 rom 1FFF");
    bus_op(16'h0123, 1, 1, 8'h00, 1, "R5 rom 0123");
    bus_op(16'h0010, 0, 1, 8'h00, 1, "R5 rom write");
    bus_op(16'h0010, 1, 1, 8'h00, 1, "R5 rom after write");

    // R6 R1 R2 distinct bytes in each bank
    bus_op(16'h2000, 0, 1, 8'h11, 1, "R1 wr bank1");
    bus_op(16'h4000, 0, 1, 8'h22, 1, "R1 wr bank2");
    bus_op(16'h6000, 0, 1, 8'h33, 1, "R1 wr bank3");
    bus_op(16'hF800, 0, 1, 8'h44, 1, "R2 wr top");
    bus_op(16'hFFFF, 0, 1, 8'h55, 1, "R2 wr top end");
    bus_op(16'h7FFF, 0, 1, 8'h66, 1, "R1 wr bank3 end");
    bus_op(16'h2000, 1, 1, 8'h00, 1, "R6 rd bank1");
    bus_op(16'h4000, 1, 1, 8'h00, 1, "R6 rd bank2");
    bus_op(16'h6000, 1, 1, 8'h00, 1, "R6 rd bank3");
    bus_op(16'hF800, 1, 1, 8'h00, 1, "R2 rd top");
    bus_op(16'hFFFF, 1, 1, 8'h00, 1, "R2 rd top end");
    bus_op(16'h7FFF, 1, 1, 8'h00, 1, "R6 rd bank3 end");

    // R4 hole
    bus_op(16'h8000, 1, 1, 8'h00, 1, "R4 hole 8000");
    bus_op(16'hF7FF, 1, 1, 8'h00, 1, "R4 hole F7FF");
    bus_op(16'hF000, 1, 1, 8'h00, 1, "R4 hole F000");
    bus_op(16'hE800, 1, 1, 8'h00, 1, "R4 hole E800");
    bus_op(16'h8000, 0, 1, 8'h77, 1, "R4 hole write");
    bus_op(16'hE000, 0, 1, 8'h78, 1, "R4 hole write2");
    bus_op(16'h2000, 1, 1, 8'h00, 1, "R4 bank1 untouched");
    bus_op(16'hF800, 1, 1, 8'h00, 1, "R4 top untouched");
    bus_op(16'h0000, 1, 1, 8'h00, 1, "R4 rom untouched");

    // R7 idle and write-line outputs
    bus_op(16'h2000, 1, 0, 8'h00, 1, "R7 no request");
    bus_op(16'h4000, 0, 0, 8'h99, 1, "R7 idle write dropped");
    bus_op(16'h4000, 1, 1, 8'h00, 1, "R7 bank2 kept");

    // R8 mirror
    bus_op(16'h2005, 0, 1, 8'h42, 1, "R8 wr 2005");
    bus_op(16'h2205, 1, 1, 8'h00, 1, "R8 rd 2205");
    bus_op(16'h3E05, 1, 1, 8'h00, 1, "R8 rd 3E05");
    bus_op(16'hFA05, 0, 1, 8'h43, 1, "R8 wr FA05");
    bus_op(16'hF805, 1, 1, 8'h00, 1, "R8 rd F805");

    // R9 writes blocked in reset and release window
    @(negedge clk); rst_n = 0;
    bus_op(16'h2000, 0, 1, 8'h99, 0, "R9 wr in reset");
    rst_n = 1;
    bus_op(16'h2000, 0, 1, 8'h98, 0, "R9 wr in window");
    bus_op(16'h2000, 1, 1, 8'h00, 1, "R9 old kept");
    bus_op(16'h2000, 0, 1, 8'h5C, 1, "R9 wr after window");
    bus_op(16'h2000, 1, 1, 8'h00, 1, "R9 new stored");

    @(negedge clk);
    #2;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule